// File: doc/BRIEF.md
# Framed Serial Transmitter with Line Break and Synchronous Clock

This block serialises bytes onto a single output line. Each frame is one low start bit, then eight data bits with the least significant bit first, then a stop period whose length is picked from four codes. Two of those codes give a fractional stop length (half a bit and one and a half bits). The line rests high. All bit timing comes from an input tick that pulses at sixteen times the bit rate. A whole bit therefore lasts sixteen ticks, and half a bit lasts eight.

When line-break mode is enabled, a break request holds the line low for thirteen bit periods instead of sending a frame. For synchronous links the block can also drive a clock output with one full cycle per start or data bit. Its rest level and the position of its edges within each bit are set by two configuration bits. The block latches its configuration when a frame or break begins, so changes made during a frame do not affect that frame.

Top module: `sertx_top`

## Requirements
- R1: After reset the line output is high, the clock output is low, busy is low and ready is high.
- R2: An accepted byte is sent as one low start bit of 16 ticks, followed by 8 data bits of 16 ticks each, least significant bit first.
- R3: The 2-bit stop code sets the stop period: 0 gives 16 ticks, 1 gives 8 ticks, 2 gives 32 ticks and 3 gives 24 ticks. Busy stays high for exactly 144 ticks plus the stop period, and the line is high during the stop period.
- R4: While the block is idle with line-break mode on, a break request drives the line low for exactly 208 ticks. Busy is high during the break, and no data is sent.
- R5: With line-break mode off, a break request has no effect: the line stays high and busy stays low.
- R6: A break request takes priority over a byte offered in the same cycle, and that byte is sent once the break ends.
- R7: Ready is low whenever busy is high. A byte is taken only in a cycle where valid and ready are both high.
- R8: With the clock enable off, the clock output stays low during frames.
- R9: The clock output rests at the polarity level outside the start and data bits, including during the stop period.
- R10: With the clock enabled, the clock output makes exactly one full cycle in each start or data bit (18 transitions per frame). With phase 0 it is at the rest level in the first half of each bit and at the opposite level in the second half. With phase 1 it is at the opposite level in the first half and at the rest level in the second half.
- R11: The stop code, clock enable, polarity and phase are latched when a frame is accepted. Changes to them during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | A byte is offered on tx_data |
| tx_ready | output | 1 | The block will take the offered byte |
| brk_req | input | 1 | Request to send a line break |
| cfg_stop | input | 2 | Stop period code |
| cfg_brk_en | input | 1 | Line-break mode enable |
| cfg_clk_en | input | 1 | Clock output enable |
| cfg_cpol | input | 1 | Rest level of the clock output |
| cfg_cpha | input | 1 | Edge placement of the clock output |
| tx_o | output | 1 | Serial line output |
| sclk_o | output | 1 | Synchronous clock output |
| busy_o | output | 1 | A frame or break is in progress |

## Verification
The assertions check the following on every cycle: ready and busy are never high together, the line is high whenever the block is idle, the line is low throughout the start bit and the break, the segment counter stays below the current segment length, the latched configuration stays stable during a frame, and a disabled clock output stays low. Other behaviours can only be shown by the bench's scenarios. These include the bit order of a byte, the exact tick count of each stop code and of the break, how breaks and pending bytes are ordered, the number and position of clock edges for each polarity and phase, and the fact that a configuration change made during a frame leaves that frame unchanged.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_BRK,
    S_START,
    S_DATA,
    S_STOP
  } sertx_state_e;

  // Stop period in ticks for each stop code, given the oversampling factor.
  function automatic int unsigned stop_ticks(input logic [1:0] code, input int unsigned ovs);
    case (code)
      2'd0:    return ovs;
      2'd1:    return ovs / 2;
      2'd2:    return 2 * ovs;
      default: return ovs + ovs / 2;
    endcase
  endfunction
endpackage

// File: rtl/sertx_seg_timer.sv
module sertx_seg_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] seg_len,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  assign done = run && tick && (cnt == seg_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (done) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_in_seg_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < seg_len));
endmodule

// File: rtl/sertx_sclk_gen.sv
module sertx_sclk_gen #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_bits,
  input  logic [CNT_W-1:0] phase,
  input  logic             en,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS / 2);

  logic second_half;
  logic toggled;

  assign second_half = (phase >= HALF);
  assign toggled     = in_bits && (cpha ? !second_half : second_half);

  always_ff @(posedge clk) begin
    if (rst)      sclk_o <= 1'b0;
    else if (en)  sclk_o <= cpol ^ toggled;
    else          sclk_o <= 1'b0;
  end

  assert_sclk_off_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> !sclk_o);
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int unsigned OVS       = 16,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned BRK_BITS  = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick16,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic                 brk_req,
  input  logic [1:0]           cfg_stop,
  input  logic                 cfg_brk_en,
  input  logic                 cfg_clk_en,
  input  logic                 cfg_cpol,
  input  logic                 cfg_cpha,
  output logic                 tx_o,
  output logic                 sclk_o,
  output logic                 busy_o
);
  import sertx_pkg::*;

  localparam int unsigned BRK_LEN = OVS * BRK_BITS;
  localparam int unsigned CNT_W   = $clog2(BRK_LEN + 1);
  localparam int unsigned IDX_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] BIT_LEN_C = CNT_W'(OVS);
  localparam logic [CNT_W-1:0] BRK_LEN_C = CNT_W'(BRK_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_BITS - 1);

  sertx_state_e         state;
  logic [DATA_BITS-1:0] shreg;
  logic [IDX_W-1:0]     bit_idx;
  logic [CNT_W-1:0]     stop_len_q;
  logic                 clk_en_q, cpol_q, cpha_q;
  logic [CNT_W-1:0]     seg_len;
  logic [CNT_W-1:0]     cnt;
  logic                 seg_done;
  logic                 brk_take;
  logic                 byte_take;
  logic                 in_bits;

  assign busy_o    = (state != S_IDLE);
  assign brk_take  = (state == S_IDLE) && brk_req && cfg_brk_en;
  assign tx_ready  = (state == S_IDLE) && !(brk_req && cfg_brk_en);
  assign byte_take = tx_valid && tx_ready;
  assign in_bits   = (state == S_START) || (state == S_DATA);

  always_comb begin
    case (state)
      S_BRK:   seg_len = BRK_LEN_C;
      S_STOP:  seg_len = stop_len_q;
      default: seg_len = BIT_LEN_C;
    endcase
  end

  sertx_seg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (busy_o),
    .tick    (tick16),
    .seg_len (seg_len),
    .cnt     (cnt),
    .done    (seg_done)
  );

  // Latched settings while a frame runs, live settings while idle.
  sertx_sclk_gen #(.CNT_W(CNT_W), .OVS(OVS)) u_sclk (
    .clk     (clk),
    .rst     (rst),
    .in_bits (in_bits),
    .phase   (cnt),
    .en      (busy_o ? clk_en_q : cfg_clk_en),
    .cpol    (busy_o ? cpol_q : cfg_cpol),
    .cpha    (cpha_q),
    .sclk_o  (sclk_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      tx_o       <= 1'b1;
      shreg      <= '0;
      bit_idx    <= '0;
      stop_len_q <= CNT_W'(stop_ticks(2'd0, OVS));
      clk_en_q   <= 1'b0;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (brk_take) begin
            state <= S_BRK;
            tx_o  <= 1'b0;
          end else if (byte_take) begin
            state      <= S_START;
            tx_o       <= 1'b0;
            shreg      <= tx_data;
            stop_len_q <= CNT_W'(stop_ticks(cfg_stop, OVS));
            clk_en_q   <= cfg_clk_en;
            cpol_q     <= cfg_cpol;
            cpha_q     <= cfg_cpha;
          end
        end
        S_BRK: begin
          if (seg_done) begin
            state <= S_IDLE;
            tx_o  <= 1'b1;
          end
        end
        S_START: begin
          if (seg_done) begin
            state   <= S_DATA;
            tx_o    <= shreg[0];
            bit_idx <= '0;
          end
        end
        S_DATA: begin
          if (seg_done) begin
            if (bit_idx == LAST_IDX) begin
              state <= S_STOP;
              tx_o  <= 1'b1;
            end else begin
              shreg   <= shreg >> 1;
              tx_o    <= shreg[1];
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        S_STOP: begin
          if (seg_done) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ready_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !tx_ready);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> tx_o);
  assert_break_low_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_BRK) |-> !tx_o);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_START) |-> !tx_o);
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(stop_len_q) && $stable(cpol_q) && $stable(cpha_q)));
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, brk_req = 1'b0;
  logic [1:0] cfg_stop = 2'd0;
  logic cfg_brk_en = 1'b0, cfg_clk_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic tx_ready, tx_o, sclk_o, busy_o;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .brk_req(brk_req), .cfg_stop(cfg_stop), .cfg_brk_en(cfg_brk_en),
    .cfg_clk_en(cfg_clk_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .tx_o(tx_o), .sclk_o(sclk_o), .busy_o(busy_o)
  );

  logic [1:0] div = '0;
  always @(posedge clk) begin
    div    <= div + 1'b1;
    tick16 <= (div == 2'd3);
  end

  // Monitor: counts ticks per frame, samples mid-bit line and quarter-bit clock.
  int   tc = 0, btot = 0, lowc = 0, sedges = 0;
  logic rec [0:11];
  logic sq4 [0:11];
  logic sq12[0:11];
  logic psclk = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!busy_o) tc = 0;
    else if (tick16) begin
      if (tc < 192) begin
        if (tc % 16 == 8)  rec[tc/16] = tx_o;
        if (tc % 16 == 4)  sq4[tc/16] = sclk_o;
        if (tc % 16 == 12) sq12[tc/16] = sclk_o;
      end
      if (!tx_o) lowc++;
      tc++;
      btot = tc;
    end
    if (busy_o && sclk_o != psclk) sedges++;
    psclk = sclk_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    btot = 0; lowc = 0; sedges = 0;
  endtask

  task automatic wait_busy(input logic lvl);
    do @(negedge clk); while (busy_o != lvl);
  endtask

  function automatic int stop_len(input logic [1:0] c);
    case (c)
      2'd0: return 16;
      2'd1: return 8;
      2'd2: return 32;
      default: return 24;
    endcase
  endfunction

  task automatic check_byte(input logic [7:0] d, input string tag);
    logic [7:0] got;
    for (int i = 0; i < 8; i++) got[i] = rec[i+1];
    chk(rec[0] == 1'b0, {tag, " start low"}, int'(rec[0]), 0);
    chk(got == d, {tag, " data LSB first"}, int'(got), int'(d));
  endtask

  // R2 R3 R8 R9 R10: send one frame and check timing, data and clock shape.
  task automatic run_frame(input logic [7:0] d, input logic [1:0] st, input logic en,
                           input logic pol, input logic pha, input string tag);
    logic exp4, exp12;
    cfg_stop = st; cfg_clk_en = en; cfg_cpol = pol; cfg_cpha = pha;
    repeat (3) @(negedge clk);
    clear_mon();
    tx_data = d; tx_valid = 1'b1;
    wait_busy(1'b1);
    tx_valid = 1'b0;
    chk(!tx_ready, {tag, " R7 ready low while busy"}, int'(tx_ready), 0);
    wait_busy(1'b0);
    @(negedge clk);
    check_byte(d, {tag, " R2"});
    chk(btot == 144 + stop_len(st), {tag, " R3 busy ticks"}, btot, 144 + stop_len(st));
    if (stop_len(st) >= 16)
      chk(rec[9] == 1'b1, {tag, " R3 stop high"}, int'(rec[9]), 1);
    chk(sedges == (en ? 18 : 0), {tag, " R10 clock transitions"}, sedges, en ? 18 : 0);
    exp4  = en & (pha ? ~pol : pol);
    exp12 = en & (pha ? pol : ~pol);
    for (int b = 0; b < 9; b++) begin
      chk(sq4[b] == exp4 && sq12[b] == exp12, {tag, " R10 R8 clock placement"},
          int'({sq4[b], sq12[b]}), int'({exp4, exp12}));
    end
    chk(sq4[9] == (en & pol), {tag, " R9 rest level in stop"}, int'(sq4[9]), int'(en & pol));
  endtask

  task automatic t_reset();
    chk(tx_o == 1'b1, "R1 line high", int'(tx_o), 1);
    chk(sclk_o == 1'b0, "R1 clock low", int'(sclk_o), 0);
    chk(busy_o == 1'b0, "R1 busy low", int'(busy_o), 0);
    chk(tx_ready == 1'b1, "R1 ready high", int'(tx_ready), 1);
  endtask

  task automatic t_break();
    cfg_brk_en = 1'b1;
    @(negedge clk);
    clear_mon();
    brk_req = 1'b1;
    wait_busy(1'b1);
    brk_req = 1'b0;
    wait_busy(1'b0);
    @(negedge clk);
    chk(lowc == 208, "R4 break low ticks", lowc, 208);
    chk(btot == 208, "R4 break busy ticks", btot, 208);
    chk(tx_o == 1'b1, "R4 line high after break", int'(tx_o), 1);
  endtask

  task automatic t_break_ignored();
    int seen = 0, lowseen = 0;
    cfg_brk_en = 1'b0;
    brk_req = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (busy_o) seen++;
      if (!tx_o) lowseen++;
    end
    brk_req = 1'b0;
    chk(seen == 0, "R5 busy stays low", seen, 0);
    chk(lowseen == 0, "R5 line stays high", lowseen, 0);
  endtask

  task automatic t_break_then_byte();
    cfg_brk_en = 1'b1; cfg_stop = 2'd0; cfg_clk_en = 1'b0;
    @(negedge clk);
    clear_mon();
    tx_data = 8'hC3; tx_valid = 1'b1; brk_req = 1'b1;
    wait_busy(1'b1);
    brk_req = 1'b0;
    wait_busy(1'b0);
    chk(lowc == 208, "R6 break sent first", lowc, 208);
    wait_busy(1'b1);
    tx_valid = 1'b0;
    wait_busy(1'b0);
    @(negedge clk);
    check_byte(8'hC3, "R6 pending byte after break");
    cfg_brk_en = 1'b0;
  endtask

  task automatic t_midframe_cfg();
    cfg_stop = 2'd0; cfg_clk_en = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    repeat (3) @(negedge clk);
    clear_mon();
    tx_data = 8'h5A; tx_valid = 1'b1;
    wait_busy(1'b1);
    tx_valid = 1'b0;
    repeat (200) @(negedge clk);
    cfg_stop = 2'd2; cfg_cpha = 1'b1; cfg_clk_en = 1'b0;
    wait_busy(1'b0);
    @(negedge clk);
    check_byte(8'h5A, "R11");
    chk(btot == 160, "R11 stop length unchanged", btot, 160);
    chk(sedges == 18, "R11 clock unchanged", sedges, 18);
    chk(sq4[8] == 1'b0 && sq12[8] == 1'b1, "R11 phase unchanged",
        int'({sq4[8], sq12[8]}), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_frame(8'hA5, 2'd0, 1'b0, 1'b0, 1'b0, "f1");
    run_frame(8'h01, 2'd1, 1'b1, 1'b0, 1'b0, "f2");
    run_frame(8'h80, 2'd2, 1'b1, 1'b1, 1'b0, "f3");
    run_frame(8'h3C, 2'd3, 1'b1, 1'b0, 1'b1, "f4");
    run_frame(8'hFF, 2'd0, 1'b1, 1'b1, 1'b1, "f5");
    run_frame(8'h00, 2'd3, 1'b0, 1'b1, 1'b1, "f6");
    t_break();
    t_break_ignored();
    t_break_then_byte();
    t_midframe_cfg();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule